// File: doc/BRIEF.md
# Switch Table Branch Resolver

This block finds the destination of a multi-way branch. Given the code-unit address of a switch instruction, a signed 32-bit distance to its jump table and a 32-bit test value, it reads the table from a code memory made of 16-bit units. The read port is synchronous: the unit at the presented address appears one cycle after the read enable. The first unit of the table names its layout. The second unit gives the number of entries. The block then resolves the branch and reports either a taken branch with its target address or a fall-through.

Two layouts are handled. A dense layout holds one lowest key and one relative target per consecutive key value. A sorted layout holds an ascending list of keys, then a list of relative targets of the same length. Every relative target counts from the switch instruction, not from the table. A layout identifier that is not recognised ends the lookup with an error flag. A new lookup is accepted only while the block is idle.

Top module: `switch_target_resolver`

## Requirements
- R1: After reset, `done`, `taken`, `badTable`, `busy` and `memRdEn` are all 0.
- R2: The table base is `instrAddr` plus `tableOff` taken as a signed count of code units, modulo 2^ADDR_W. The first read of a lookup goes to that address.
- R3: Every 32-bit table value is built from two consecutive units, with the lower address holding bits 15:0. Keys are compared as signed numbers.
- R4: Identifier 0x0100 at base+0 selects the dense layout, with the entry count at base+1, the lowest key at base+2 and relative target k at base+4+2k. When test minus lowest key equals k and 0 <= k < count, the result is taken with target = `instrAddr` + target k.
- R5: In the dense layout, a difference below 0 or at least count gives a fall-through. The difference is computed without overflow.
- R6: Identifier 0x0200 selects the sorted layout, with key i at base+2+2i and target i at base+2+2·count+2i. A key equal to the test value gives taken with target = `instrAddr` + target i.
- R7: In the sorted layout, the scan stops at the first key greater than the test value. Each lookup reads exactly: 2 units for the header, 2 per key examined (the dense lowest key included), and 2 for a selected target.
- R8: Any other identifier ends the lookup with `badTable`=1 and `taken`=0.
- R9: A fall-through, including one from an empty table, reports `taken`=0 with `target` = `instrAddr` + FALL_LEN (3 by default).
- R10: Each lookup ends with `done` high for exactly one cycle. `taken`, `target` and `badTable` are valid in that cycle, and `busy` is low from then on.
- R11: A `startIn` pulse while `busy` is high is ignored: there is no extra `done`, and the running lookup's result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start a lookup (used only when idle) |
| instrAddr | input | ADDR_W | Code-unit address of the switch instruction |
| tableOff | input | 32 | Signed offset from instruction to table, in units |
| testVal | input | 32 | Value to switch on |
| memRdEn | output | 1 | Code memory read enable |
| memAddr | output | ADDR_W | Code memory unit address |
| memData | input | 16 | Unit read, valid one cycle after `memRdEn` |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| target | output | ADDR_W | Resolved address (target or fall-through) |
| badTable | output | 1 | Unknown table identifier |

## Verification
The hardest case to reach is early termination of the sorted scan, because the result looks identical to a full scan that finds no match. The stimulus uses tables with negative and positive keys and test values that fall between keys, below the first key and above the last key. The monitor counts read enables per lookup, so a scan that stops too late or too early shows up as a wrong read count. A second start pulse injected in the middle of a lookup, with different arguments, exercises the ignore rule.

// File: rtl/swres_pkg.sv
package swres_pkg;

  localparam logic [15:0] ID_DENSE  = 16'h0100;
  localparam logic [15:0] ID_SORTED = 16'h0200;

  typedef enum logic [1:0] {W_HDR, W_BASE, W_KEY, W_TGT} wordKind_t;

  typedef struct packed {
    logic      loadArgs;
    logic      rdEn;
    logic      rdHi;
    logic      capLo;
    logic      capHdr;
    logic      capBase;
    logic      incIdx;
    logic      sorted;
    wordKind_t kind;
    logic      finish;
    logic      finTaken;
    logic      finBad;
  } dpCtl_t;

  typedef struct packed {
    logic hdrDense;
    logic hdrSorted;
    logic hdrEmpty;
    logic inRange;
    logic keyEq;
    logic keyGt;
    logic idxLast;
  } dpStat_t;

endpackage

// File: rtl/swres_ctrl.sv
module swres_ctrl
  import swres_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    busy
);

  typedef enum logic [1:0] {S_IDLE, S_RDLO, S_RDHI, S_EVAL} state_t;

  state_t    state, nState;
  wordKind_t kind, nKind;
  logic      sortedReg, nSorted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kind      <= W_HDR;
      sortedReg <= 1'b0;
    end else begin
      state     <= nState;
      kind      <= nKind;
      sortedReg <= nSorted;
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.kind   = kind;
    ctl.sorted = sortedReg;
    nState     = state;
    nKind      = kind;
    nSorted    = sortedReg;
    unique case (state)
      S_IDLE: begin
        if (startIn) begin
          ctl.loadArgs = 1'b1;
          nKind        = W_HDR;
          nState       = S_RDLO;
        end
      end
      S_RDLO: begin
        ctl.rdEn = 1'b1;
        nState   = S_RDHI;
      end
      S_RDHI: begin
        ctl.rdEn  = 1'b1;
        ctl.rdHi  = 1'b1;
        ctl.capLo = 1'b1;
        nState    = S_EVAL;
      end
      S_EVAL: begin
        nState = S_RDLO;
        unique case (kind)
          W_HDR: begin
            ctl.capHdr = 1'b1;
            if (stat.hdrDense) begin
              nSorted = 1'b0;
              nKind   = W_BASE;
            end else if (stat.hdrSorted) begin
              nSorted = 1'b1;
              nKind   = W_KEY;
              if (stat.hdrEmpty) ctl.finish = 1'b1;
            end else begin
              ctl.finish = 1'b1;
              ctl.finBad = 1'b1;
            end
          end
          W_BASE: begin
            ctl.capBase = 1'b1;
            if (stat.inRange) nKind = W_TGT;
            else ctl.finish = 1'b1;
          end
          W_KEY: begin
            if (stat.keyEq) nKind = W_TGT;
            else if (stat.keyGt || stat.idxLast) ctl.finish = 1'b1;
            else ctl.incIdx = 1'b1;
          end
          W_TGT: begin
            ctl.finish   = 1'b1;
            ctl.finTaken = 1'b1;
          end
          default: ctl.finish = 1'b1;
        endcase
        if (ctl.finish) nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/swres_dp.sv
module swres_dp
  import swres_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int FALL_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [31:0]       tableOff,
  input  logic [31:0]       testVal,
  input  logic [15:0]       memData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output dpStat_t           stat,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              badTable
);

  localparam int OFF_W = CNT_W + 3;

  logic [ADDR_W-1:0] instrReg, tblReg;
  logic [31:0]       testReg;
  logic [15:0]       loReg;
  logic [CNT_W-1:0]  cntReg, idxReg;
  logic [31:0]       word;
  logic [32:0]       diff;
  logic [OFF_W-1:0]  unitOff;

  assign word = {memData, loReg};
  assign diff = {testReg[31], testReg} - {word[31], word};

  always_comb begin
    stat           = '0;
    stat.hdrDense  = (word[15:0] == ID_DENSE);
    stat.hdrSorted = (word[15:0] == ID_SORTED);
    stat.hdrEmpty  = (word[31:16] == '0);
    stat.inRange   = !diff[32] && (diff < 33'(cntReg));
    stat.keyEq     = (word == testReg);
    stat.keyGt     = ($signed(word) > $signed(testReg));
    stat.idxLast   = ({1'b0, idxReg} + 1'b1) == {1'b0, cntReg};
  end

  always_comb begin
    unique case (ctl.kind)
      W_HDR:   unitOff = '0;
      W_BASE:  unitOff = OFF_W'(2);
      W_KEY:   unitOff = OFF_W'(2) + (OFF_W'(idxReg) << 1);
      default: unitOff = ctl.sorted
                         ? OFF_W'(2) + (OFF_W'(cntReg) << 1) + (OFF_W'(idxReg) << 1)
                         : OFF_W'(4) + (OFF_W'(idxReg) << 1);
    endcase
  end

  assign memRdEn = ctl.rdEn;
  assign memAddr = tblReg + ADDR_W'(unitOff) + ADDR_W'(ctl.rdHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrReg <= '0;
      tblReg   <= '0;
      testReg  <= '0;
      loReg    <= '0;
      cntReg   <= '0;
      idxReg   <= '0;
      done     <= 1'b0;
      taken    <= 1'b0;
      target   <= '0;
      badTable <= 1'b0;
    end else begin
      if (ctl.loadArgs) begin
        instrReg <= instrAddr;
        tblReg   <= instrAddr + ADDR_W'($signed(tableOff));
        testReg  <= testVal;
      end
      if (ctl.capLo) loReg <= memData;
      if (ctl.capHdr) begin
        cntReg <= word[31:16];
        idxReg <= '0;
      end
      if (ctl.capBase) idxReg <= diff[CNT_W-1:0];
      if (ctl.incIdx)  idxReg <= idxReg + 1'b1;
      done <= ctl.finish;
      if (ctl.finish) begin
        taken    <= ctl.finTaken;
        badTable <= ctl.finBad;
        target   <= ctl.finTaken ? instrReg + ADDR_W'($signed(word))
                                 : instrReg + ADDR_W'(FALL_LEN);
      end
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an error result never reports a taken branch
  a_r8_bad_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (done && badTable) |-> !taken);

  // R3: the high unit is fetched from the address right after the low unit
  a_r3_hi_follows_lo: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && !ctl.rdHi) |=> (memRdEn && ctl.rdHi && memAddr == $past(memAddr) + 1'b1));

  // R7: the key scan never steps past the last entry
  a_r7_scan_bound: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incIdx |-> ({1'b0, idxReg} + 1'b1) < {1'b0, cntReg});

endmodule

// File: rtl/switch_target_resolver.sv
module switch_target_resolver
  import swres_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int FALL_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [31:0]       tableOff,
  input  logic [31:0]       testVal,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memData,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] target,
  output logic              badTable
);

  dpCtl_t  ctl;
  dpStat_t stat;

  swres_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .stat   (stat),
    .ctl    (ctl),
    .busy   (busy)
  );

  swres_dp #(.ADDR_W(ADDR_W), .CNT_W(16), .FALL_LEN(FALL_LEN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .instrAddr(instrAddr),
    .tableOff (tableOff),
    .testVal  (testVal),
    .memData  (memData),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .stat     (stat),
    .done     (done),
    .taken    (taken),
    .target   (target),
    .badTable (badTable)
  );

  // R10: busy has dropped by the time done is seen
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11: a start while busy does not restart the read sequence at the header
  a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startIn && !done && memRdEn) |=> busy);

endmodule

// File: tb/switch_target_resolver_tb_top.sv
`timescale 1ns/1ps
module switch_target_resolver_tb_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0;
  logic [AW-1:0] instrAddr = '0;
  logic [31:0]   tableOff = '0;
  logic [31:0]   testVal = '0;
  logic          memRdEn;
  logic [AW-1:0] memAddr;
  logic [15:0]   memData;
  logic          busy, done, taken, badTable;
  logic [AW-1:0] target;

  always #2 clk = ~clk;

  switch_target_resolver #(.ADDR_W(AW), .FALL_LEN(3)) dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .instrAddr(instrAddr),
    .tableOff(tableOff), .testVal(testVal), .memRdEn(memRdEn),
    .memAddr(memAddr), .memData(memData), .busy(busy), .done(done),
    .taken(taken), .target(target), .badTable(badTable)
  );

  logic [15:0] mem [0:1023];
  logic [15:0] memQ;
  always_ff @(posedge clk) if (memRdEn) memQ <= mem[memAddr[9:0]];
  assign memData = memQ;

  typedef struct {
    bit          tk;
    bit          bad;
    logic [15:0] tgt;
    int          reads;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0, fails = 0;
  int readCnt = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string what, input string act, input string expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", what, act, expd);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [15:0] a);
    return {mem[10'(a + 16'd1)], mem[10'(a)]};
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    mem[a]   = v[15:0];
    mem[a+1] = v[31:16];
  endtask

  // Reference lookup over the bench's copy of the tables
  function automatic exp_t model(input logic [15:0] ia, input logic [31:0] off,
                                 input logic [31:0] tv);
    exp_t e;
    logic [15:0] b, id, cnt;
    logic [31:0] k;
    longint d;
    e.tk = 0; e.bad = 0; e.tgt = ia + 16'd3; e.reads = 2;
    b   = ia + off[15:0];
    id  = mem[10'(b)];
    cnt = mem[10'(b + 16'd1)];
    if (id == 16'h0100) begin
      k = rd32(b + 16'd2);
      e.reads += 2;
      d = longint'($signed(tv)) - longint'($signed(k));
      if (d >= 0 && d < longint'(cnt)) begin
        e.reads += 2;
        e.tk = 1;
        e.tgt = ia + rd32(b + 16'd4 + 16'(2 * d))[15:0];
      end
    end else if (id == 16'h0200) begin
      for (int i = 0; i < int'(cnt); i++) begin
        k = rd32(b + 16'd2 + 16'(2 * i));
        e.reads += 2;
        if (k == tv) begin
          e.reads += 2;
          e.tk = 1;
          e.tgt = ia + rd32(b + 16'd2 + 16'(2 * cnt) + 16'(2 * i))[15:0];
          break;
        end
        if ($signed(k) > $signed(tv)) break;
      end
    end else begin
      e.bad = 1;
    end
    return e;
  endfunction

  task automatic lookup(input logic [15:0] ia, input logic [31:0] off,
                        input logic [31:0] tv, input string tag, input bit intrude);
    exp_t e;
    e = model(ia, off, tv);
    e.tag = tag;
    sbq.push_back(e);
    @(posedge clk); #1;
    instrAddr = ia; tableOff = off; testVal = tv; startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
    if (intrude) begin
      // R11: second start with different arguments while busy
      instrAddr = ia + 16'd7; tableOff = 32'd0; testVal = ~tv; startIn = 1'b1;
      @(posedge clk); #1;
      startIn = 1'b0;
    end
    while (!done) begin @(posedge clk); #1; end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (memRdEn) readCnt++;
      if (done) begin
        if (sbq.size() == 0) begin
          check(0, "R10/R11 unexpected done", "done", "none");
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(taken == e.tk && target == e.tgt && badTable == e.bad,
                $sformatf("%s result", e.tag),
                $sformatf("tk=%0d tgt=%h bad=%0d", taken, target, badTable),
                $sformatf("tk=%0d tgt=%h bad=%0d", e.tk, e.tgt, e.bad));
          check(readCnt == e.reads, $sformatf("R7 %s read count", e.tag),
                $sformatf("%0d", readCnt), $sformatf("%0d", e.reads));
        end
        readCnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", "timeout", "completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    // Dense table at 100: count 3, lowest key 10
    mem[100] = 16'h0100; mem[101] = 16'd3;
    put32(102, 32'd10);
    put32(104, 32'd20); put32(106, -32'sd6); put32(108, 32'h0001_0040);
    // Sorted table at 200: keys -50,-3,7,1000
    mem[200] = 16'h0200; mem[201] = 16'd4;
    put32(202, -32'sd50); put32(204, -32'sd3); put32(206, 32'd7); put32(208, 32'd1000);
    put32(210, 32'd30); put32(212, 32'd40); put32(214, 32'd50); put32(216, 32'd60);
    // Unknown identifier at 400
    mem[400] = 16'h0300; mem[401] = 16'd2;
    // Empty sorted at 500, empty dense at 520
    mem[500] = 16'h0200; mem[501] = 16'd0;
    mem[520] = 16'h0100; mem[521] = 16'd0; put32(522, 32'd5);
    // Dense at 256 reached through address wrap: key -7
    mem[256] = 16'h0100; mem[257] = 16'd1;
    put32(258, -32'sd7); put32(260, 32'h30);

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(!done && !taken && !badTable && !busy && !memRdEn, "R1 reset outputs",
          $sformatf("%b%b%b%b%b", done, taken, badTable, busy, memRdEn), "00000");
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    lookup(16'd80, 32'd20, 32'd10, "R4 dense first", 0);
    lookup(16'd80, 32'd20, 32'd11, "R4 dense negative rel", 0);
    lookup(16'd80, 32'd20, 32'd12, "R3 R4 dense wide rel", 0);
    lookup(16'd80, 32'd20, 32'd9, "R5 R9 dense below", 0);
    lookup(16'd80, 32'd20, 32'd13, "R5 dense above", 0);
    lookup(16'd80, 32'd20, 32'h8000_000A, "R5 dense overflow", 0);
    lookup(16'd300, -32'sd100, -32'sd50, "R2 R6 sorted first key", 0);
    lookup(16'd300, -32'sd100, 32'd1000, "R6 sorted last key", 0);
    lookup(16'd300, -32'sd100, 32'd7, "R3 R6 sorted middle", 0);
    lookup(16'd300, -32'sd100, 32'd0, "R7 sorted early stop", 0);
    lookup(16'd300, -32'sd100, -32'sd100, "R7 sorted stop at first", 0);
    lookup(16'd300, -32'sd100, 32'd2000, "R7 R9 sorted full scan", 0);
    lookup(16'd390, 32'd10, 32'd1, "R8 bad identifier", 0);
    lookup(16'd500, 32'd0, 32'd0, "R9 empty sorted", 0);
    lookup(16'd515, 32'd5, 32'd5, "R9 empty dense", 0);
    lookup(16'hFFF0, 32'h0000_0110, -32'sd7, "R2 wrapped base", 0);
    lookup(16'd300, -32'sd100, 32'd1000, "R11 start while busy", 1);
    lookup(16'd390, 32'd10, 32'd1, "R11 start while busy short", 1);

    repeat (20) @(posedge clk);
    check(sbq.size() == 0, "R10 all results seen", $sformatf("%0d", sbq.size()), "0");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule